// File: doc/BRIEF.md
# Four-Role Self-Test Register

`selftest_reg` is a bank of flip-flops of parameterized width that can stand in for the ordinary state register of a logic block. A two-bit role input chooses what happens at each clock edge. In one role the bank is a plain parallel register. In another it is a pseudo-random stimulus source. In a third it folds a stream of parallel response words into a signature. In the last it is a serial shift chain, used to load a seed or to read a result out.

The stimulus and signature roles share one modular (internal-XOR) feedback network. A step multiplies the current state by x modulo the characteristic polynomial. An XOR gate is placed only at a stage whose polynomial coefficient is 1. In the signature role, each step additionally XORs the parallel data word into the stepped state.

Typical use follows four steps:
1. Seed the bank through the register role or the shift role.
2. Run the stimulus role for the logic downstream, or the signature role for the logic upstream.
3. Read the result in parallel, or shift it out.
4. Compare the result against a precomputed good signature.

Top module: `selftest_reg`

## Requirements
- R1: While `rst_n` is low, the state and `par_out` are all zeros and `ser_out` is 0. This holds whatever values the other inputs carry.
- R2: With `role` = 2'b11 (register), the state loads `par_in` at each rising clock edge.
- R3: With `role` = 2'b00 (shift), each edge moves stage i into stage i+1 and loads `ser_in` into stage 0. `ser_out` always shows the top stage, WIDTH-1.
- R4: With `role` = 2'b01 (stimulus) and a non-zero state, the next state is the state times x modulo p(x). Stage 0 takes the top stage. Stage i (i ≥ 1) takes stage i-1, XORed with the top stage when bit i of `POLY` is 1. Bit 0 of `POLY` is ignored, because both the constant term and the x^WIDTH term are always present.
- R5: In the stimulus role, a non-zero state never becomes zero. With the default primitive polynomial (x^8+x^4+x^3+x^2+1, `POLY` = 8'h1D), a seed reappears after exactly 255 steps, and all 255 states on the way are distinct.
- R6: In the stimulus role, an all-zero state is replaced by the value 1 (stage 0 set) on the next edge, so the generator never locks up.
- R7: With `role` = 2'b10 (signature), the next state is the R4 step of the current state XORed bit by bit with `par_in`. This role has no zero escape, so a zero state with zero data stays zero.
- R8: `par_out` always equals the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the state |
| role | input | 2 | 00 shift, 01 stimulus, 10 signature, 11 register |
| par_in | input | WIDTH | Parallel data for the register and signature roles |
| ser_in | input | 1 | Serial input into stage 0 in the shift role |
| par_out | output | WIDTH | Current state |
| ser_out | output | 1 | Top stage of the state |

## Verification
The bench builds the block with its defaults: WIDTH = 8 and the primitive polynomial 8'h1D. An 8-bit state makes the whole stimulus cycle of 255 steps cheap to walk. That walk lets the bench prove both the exact period and the distinctness of every state. The default polynomial has taps at several inner stages and none at others, so the bench exercises both the XOR and the plain-wire stage variants. It covers both the feedback and the no-feedback case of the top stage, as well as the zero-escape and zero-hold corners.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        ROLE_SHIFT = 2'b00,
        ROLE_STIM  = 2'b01,
        ROLE_SIG   = 2'b10,
        ROLE_HOLD  = 2'b11
    } role_e;

endpackage

// File: rtl/selftest_step.sv
// Multiply-by-x modulo p(x): modular feedback, one XOR only where a tap exists.
module selftest_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] stepped_o
);
    localparam int TOP = WIDTH - 1;

    logic fb;
    assign fb = cur_i[TOP];

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stepped_o[i] = fb;
        end else if (POLY[i]) begin : g_tap
            assign stepped_o[i] = cur_i[i-1] ^ fb;
        end else begin : g_wire
            assign stepped_o[i] = cur_i[i-1];
        end
    end
endmodule

// File: rtl/selftest_next.sv
// Role multiplexer: picks the next state from the four behaviours.
module selftest_next #(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       role_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] stepped_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] nxt_o
);
    import selftest_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    role_e role;
    logic  is_zero;

    assign role    = role_e'(role_i);
    assign is_zero = (cur_i == '0);

    always_comb begin
        nxt_o = cur_i;
        unique case (role)
            ROLE_SHIFT: nxt_o = {cur_i[WIDTH-2:0], ser_i};
            ROLE_STIM:  nxt_o = is_zero ? ONE : stepped_i;
            ROLE_SIG:   nxt_o = stepped_i ^ par_i;
            ROLE_HOLD:  nxt_o = par_i;
            default:    nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       role,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);
    import selftest_pkg::*;

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] cells;
    } bank_t;

    bank_t            bank_d, bank_q;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] nxt;

    selftest_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
        .cur_i     (bank_q.cells),
        .stepped_o (stepped)
    );

    selftest_next #(.WIDTH(WIDTH)) u_next (
        .role_i    (role),
        .cur_i     (bank_q.cells),
        .stepped_i (stepped),
        .par_i     (par_in),
        .ser_i     (ser_in),
        .nxt_o     (nxt)
    );

    always_comb begin
        bank_d       = bank_q;
        bank_d.cells = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign par_out = bank_q.cells;
    assign ser_out = bank_q.cells[TOP];

    // R2: register role captures parallel data
    assert_hold_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_HOLD) |=> (par_out == $past(par_in)));

    // R3: shift role moves data one stage up and takes ser_in at stage 0
    assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_SHIFT) |=> (par_out[TOP:1] == $past(par_out[TOP-1:0]))
                                 && (par_out[0] == $past(ser_in)));

    // R4: stimulus role feeds the top stage back into stage 0
    assert_stim_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_STIM && par_out != '0) |=> (par_out[0] == $past(par_out[TOP])));

    // R5 / R6: the stimulus role never leaves the state at zero
    assert_stim_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_STIM) |=> (par_out != '0));

    // R6: zero state escapes to the value one
    assert_zero_escape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_STIM && par_out == '0) |=> (par_out == WIDTH'(1)));

    // R7: signature role folds data bit 0 with the top stage
    assert_sig_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_SIG) |=> (par_out[0] == $past(par_out[TOP] ^ par_in[0])));

endmodule

// File: tb/sim_selftest_reg.sv
module sim_selftest_reg;
    localparam int           W      = 8;
    localparam logic [W-1:0] P      = 8'h1D;
    localparam time          PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   role;
    logic [W-1:0] par_in;
    logic         ser_in;
    logic [W-1:0] par_out;
    logic         ser_out;

    int           checks = 0;
    int           fails  = 0;
    bit           done   = 0;
    logic [W-1:0] m;

    always #(PERIOD/2) clk = ~clk;

    selftest_reg #(.WIDTH(W), .POLY(P)) u0 (
        .clk(clk), .rst_n(rst_n), .role(role), .par_in(par_in),
        .ser_in(ser_in), .par_out(par_out), .ser_out(ser_out)
    );

    function automatic logic [W-1:0] times_x(input logic [W-1:0] v);
        int t;
        t = int'(v) * 2;
        if (t >= (1 << W)) t = t ^ ((1 << W) | int'(P) | 1);
        return t[W-1:0];
    endfunction

    // R8: every compare also checks that par_out equals the modelled state
    task automatic check(input string req, input logic [W-1:0] ev, input logic es);
        checks++;
        if (par_out !== ev || ser_out !== es) begin
            fails++;
            $display("FAIL %s: par_out=%h ser_out=%b expected %h %b", req, par_out, ser_out, ev, es);
        end
    endtask

    task automatic step(input logic [1:0] r, input logic [W-1:0] d, input logic si, input string req);
        role = r; par_in = d; ser_in = si;
        @(posedge clk);
        case (r)
            2'b11: m = d;
            2'b00: m = {m[W-2:0], si};
            2'b01: m = (m == '0) ? W'(1) : times_x(m);
            default: m = times_x(m) ^ d;
        endcase
        @(negedge clk);
        check(req, m, m[W-1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit   seen [0:255];
        int   distinct;
        logic [W-1:0] seed;
        rst_n = 1'b0; role = 2'b11; par_in = 8'hAA; ser_in = 1'b1; m = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", '0, 1'b0);
        rst_n = 1'b1;

        // R2 register role
        step(2'b11, 8'h5A, 1'b0, "R2");
        step(2'b11, 8'hFF, 1'b0, "R2");
        step(2'b11, 8'h81, 1'b1, "R2");
        step(2'b11, 8'h00, 1'b0, "R2");

        // R6 zero escape
        step(2'b01, 8'hFF, 1'b0, "R6");

        // R4 step with top bit set
        step(2'b11, 8'h80, 1'b0, "R2");
        step(2'b01, 8'h00, 1'b0, "R4 tap");

        // R5 full period from seed
        seed = 8'h01;
        step(2'b11, seed, 1'b0, "R2");
        for (int k = 0; k < 256; k++) seen[k] = 0;
        distinct = 0;
        for (int k = 0; k < 255; k++) begin
            step(2'b01, 8'h00, 1'b0, "R4");
            if (!seen[par_out]) distinct++;
            seen[par_out] = 1;
        end
        checks++;
        if (par_out !== seed || distinct != 255 || seen[0]) begin
            fails++;
            $display("FAIL R5: state=%h distinct=%0d expected %h 255", par_out, distinct, seed);
        end

        // R7 signature role
        step(2'b11, 8'h00, 1'b0, "R2");
        step(2'b10, 8'h00, 1'b0, "R7 zero hold");
        for (int k = 0; k < 20; k++)
            step(2'b10, W'(k * 37 + 3), 1'b0, "R7");

        // R3 shift role
        for (int k = 0; k < 8; k++) step(2'b00, 8'hC3, (8'hB4 >> k) & 1'b1, "R3");
        for (int k = 0; k < 8; k++) step(2'b00, 8'h3C, 1'b0, "R3 unload");

        // mixed roles
        for (int k = 0; k < 60; k++)
            step(2'(k % 4), W'(k * 29 + 11), k[1], "R8 mix");

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        m = '0;
        check("R1 async", '0, 1'b0);
        rst_n = 1'b1;
        step(2'b01, 8'h00, 1'b0, "R6 after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule